// File: doc/BRIEF.md
# Serial Bit-Rate and Frame Tick Generator

This block turns a peripheral clock into the timing strobes a FIFO-based serial port needs. A two-stage divider (a power-of-four prescaler chosen by a 2-bit select field, followed by an N+1 divider set by an 8-bit rate register) produces an oversampling strobe. The oversampling strobe is divided by 32 to give one strobe per bit, and the bit strobe is divided by 10 to give one strobe per frame, which is one start bit, eight data bits and one stop bit. The bit rate is therefore the peripheral clock divided by 32 × prescale × (N + 1).

When the external-clock mode input is high, the internal dividers are bypassed. The port's external clock pin is brought into the clock domain through two flip-flops, and each rising edge it shows becomes one oversampling strobe. A write to either the select field or the rate register restarts every counter in the chain. The first strobe after a write therefore comes a full period later, with no partial period left over from the old setting.

All three outputs are single-cycle pulses in the peripheral clock domain. They are meant to be used as enables by the transmitter, the receiver and the FIFO status logic of the port.

Top module: `serial_rate_gen`

## Requirements
- R1: The 2-bit select value 0, 1, 2 or 3 sets a prescale ratio of 1, 4, 16 or 64 peripheral clocks.
- R2: With rate register value N and prescale ratio Q, `os_tick` pulses once every Q×(N+1) cycles. The first pulse comes in cycle Q×(N+1)−1, where cycle 0 is the first cycle after the restarting clock edge.
- R3: `bit_tick` pulses together with every OVERSAMPLE-th `os_tick` and never without one. After a restart, the first `bit_tick` coincides with the OVERSAMPLE-th `os_tick`.
- R4: `frame_tick` pulses together with every FRAME_BITS-th `bit_tick` and never without one.
- R5: A write strobe on `sel_wr` or `rate_wr` loads the value and clears the prescaler, rate, bit and frame counters at that clock edge. No strobe is output during a cycle in which a write strobe is high.
- R6: While `ext_mode` is 1, the rate register and the select field have no effect. A rising edge of `ext_clk` that is set up before clock edge A gives one `os_tick` pulse of one cycle in the cycle that follows the clock edge after A.
- R7: While `rst_n` is low, all strobes are 0. After reset the select field and the rate register are 0, so `os_tick` is high from the first cycle after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_wr | input | 1 | Write strobe for the prescale select field |
| sel_din | input | SEL_W | New prescale select value |
| rate_wr | input | 1 | Write strobe for the rate register |
| rate_din | input | RATE_W | New rate register value N |
| ext_mode | input | 1 | 1 selects the external clock as the oversampling base |
| ext_clk | input | 1 | Asynchronous external clock |
| os_tick | output | 1 | Oversampling strobe |
| bit_tick | output | 1 | One strobe per bit period |
| frame_tick | output | 1 | One strobe per frame |

## Verification
The bench builds the block with OVERSAMPLE=4 and FRAME_BITS=3, and keeps the default 2-bit select field and 8-bit rate register. The full rate range (N=255) and every prescale ratio up to 64 are therefore tested at their real widths. The shortened bit and frame dividers bring first-strobe positions and pulse counts for all three strobes within a few dozen cycles, and the external-clock tests do the same for the path that bypasses the dividers.

// File: rtl/serial_rate_pkg.sv
// Shared helpers for the serial rate generator.
// Assumes select fields stay small (prescale ratios up to 4**(2**SEL_W-1)).
package serial_rate_pkg;

    // Counter width able to hold the largest prescale count for a select width.
    function automatic int presc_width(input int sel_w);
        return 2 * ((1 << sel_w) - 1);
    endfunction

endpackage

// File: rtl/rate_prescaler.sv
// Internal base divider: a power-of-four prescaler followed by an N+1 divider.
// Produces os_int for one cycle per prescale*(rate+1) cycles while run is high.
// Assumes clr is raised whenever sel or rate change, so the counters never
// hold a value beyond the new terminal count.
module rate_prescaler
    import serial_rate_pkg::*;
#(
    parameter int SEL_W  = 2,
    parameter int RATE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              clr,
    input  logic [SEL_W-1:0]  sel,
    input  logic [RATE_W-1:0] rate,
    output logic              os_int
);
    localparam int PRE_W = presc_width(SEL_W);

    logic [PRE_W-1:0]  pre_cnt;
    logic [PRE_W-1:0]  pre_last;
    logic [RATE_W-1:0] div_cnt;
    logic              pre_tick;
    int                shamt;

    // Terminal prescale count: 4**sel - 1 as a mask of 2*sel ones.
    always_comb begin
        shamt    = PRE_W - 2 * int'(sel);
        pre_last = {PRE_W{1'b1}} >> shamt;
    end

    assign pre_tick = run && (pre_cnt == pre_last);
    assign os_int   = pre_tick && (div_cnt == rate);

    // Advance the prescaler every cycle and the rate divider on prescaler wrap.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            pre_cnt <= '0;
            div_cnt <= '0;
        end else if (run) begin
            pre_cnt <= pre_tick ? '0 : pre_cnt + PRE_W'(1);
            if (pre_tick)
                div_cnt <= (div_cnt == rate) ? '0 : div_cnt + RATE_W'(1);
        end
    end

    assert_pre_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        pre_cnt <= pre_last)
        else $error("prescale count beyond terminal value");

    assert_div_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        div_cnt <= rate)
        else $error("rate count beyond register value");

    assert_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (pre_cnt == '0 && div_cnt == '0))
        else $error("counters not cleared after write");

endmodule

// File: rtl/ext_edge_sync.sv
// Brings an asynchronous external clock into the clk domain through two
// flip-flops and reports each rising edge as a one-cycle pulse.
// Assumes the external clock stays high and low for at least two clk cycles each.
module ext_edge_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_in,
    output logic rise
);
    logic meta_q;
    logic sync_q;
    logic prev_q;

    // Two-stage synchronizer plus one delay stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= ext_in;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign rise = sync_q && !prev_q;

    assert_rise_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise)
        else $error("edge pulse longer than one cycle");

endmodule

// File: rtl/strobe_divider.sv
// Modulo-MOD strobe divider: out_tick fires together with every MOD-th in_tick.
// Assumes MOD >= 2; clr restarts the count at the next edge.
module strobe_divider #(
    parameter int MOD = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic in_tick,
    output logic out_tick
);
    localparam int CNT_W = (MOD > 2) ? $clog2(MOD) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(MOD - 1);

    logic [CNT_W-1:0] cnt;

    assign out_tick = in_tick && (cnt == LAST);

    // Count input strobes, wrapping on the terminal one.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            cnt <= '0;
        else if (in_tick)
            cnt <= (cnt == LAST) ? '0 : cnt + CNT_W'(1);
    end

    // Covers R3 for the bit stage and R4 for the frame stage.
    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST)
        else $error("divider count beyond modulus");

    assert_out_needs_in_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_tick |-> in_tick)
        else $error("divider output without input strobe");

endmodule

// File: rtl/serial_rate_gen.sv
// Serial bit-rate and frame tick generator.
// Holds the prescale select and rate registers, picks the internal divider or
// the synchronized external clock as the oversampling base, and divides that
// down to bit and frame strobes. Any register write restarts the whole chain.
// Assumes ext_mode changes are followed by a register write when phase matters.
module serial_rate_gen #(
    parameter int SEL_W      = 2,
    parameter int RATE_W     = 8,
    parameter int OVERSAMPLE = 32,
    parameter int FRAME_BITS = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_wr,
    input  logic [SEL_W-1:0]  sel_din,
    input  logic              rate_wr,
    input  logic [RATE_W-1:0] rate_din,
    input  logic              ext_mode,
    input  logic              ext_clk,
    output logic              os_tick,
    output logic              bit_tick,
    output logic              frame_tick
);
    logic [SEL_W-1:0]  sel_q;
    logic [RATE_W-1:0] rate_q;
    logic              live_q;
    logic              any_wr;
    logic              os_int;
    logic              ext_rise;

    assign any_wr = sel_wr || rate_wr;

    // Configuration registers, loaded by their write strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= '0;
            rate_q <= '0;
        end else begin
            if (sel_wr)
                sel_q <= sel_din;
            if (rate_wr)
                rate_q <= rate_din;
        end
    end

    // Marks the chain live from the first edge after reset is released.
    always_ff @(posedge clk) begin
        if (!rst_n)
            live_q <= 1'b0;
        else
            live_q <= 1'b1;
    end

    rate_prescaler #(
        .SEL_W  (SEL_W),
        .RATE_W (RATE_W)
    ) u_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (live_q && !ext_mode),
        .clr    (any_wr),
        .sel    (sel_q),
        .rate   (rate_q),
        .os_int (os_int)
    );

    ext_edge_sync u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .ext_in (ext_clk),
        .rise   (ext_rise)
    );

    // Oversampling strobe from the selected base, silent in write cycles.
    always_comb begin
        os_tick = live_q && !any_wr && (ext_mode ? ext_rise : os_int);
    end

    strobe_divider #(.MOD(OVERSAMPLE)) u_bitdiv (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (any_wr),
        .in_tick  (os_tick),
        .out_tick (bit_tick)
    );

    strobe_divider #(.MOD(FRAME_BITS)) u_framediv (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (any_wr),
        .in_tick  (bit_tick),
        .out_tick (frame_tick)
    );

    assert_bit_on_os_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> os_tick)
        else $error("bit strobe without oversampling strobe");

    assert_frame_on_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_tick |-> bit_tick)
        else $error("frame strobe without bit strobe");

    assert_ext_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_mode && os_tick) |=> !os_tick)
        else $error("external-mode strobe longer than one cycle");

endmodule

// File: tb/serial_rate_gen_tb.sv
module serial_rate_gen_tb;
    localparam int OS = 4;
    localparam int FB = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sel_wr = 1'b0;
    logic [1:0] sel_din = '0;
    logic       rate_wr = 1'b0;
    logic [7:0] rate_din = '0;
    logic       ext_mode = 1'b0;
    logic       ext_clk = 1'b0;
    logic       os_tick, bit_tick, frame_tick;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    int first_os, first_bit, first_frame;
    int cnt_os, cnt_bit, cnt_frame;

    always #2 clk = ~clk;

    serial_rate_gen #(
        .SEL_W(2), .RATE_W(8), .OVERSAMPLE(OS), .FRAME_BITS(FB)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .sel_wr(sel_wr), .sel_din(sel_din),
        .rate_wr(rate_wr), .rate_din(rate_din), .ext_mode(ext_mode),
        .ext_clk(ext_clk), .os_tick(os_tick), .bit_tick(bit_tick),
        .frame_tick(frame_tick)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_eq(input string req, input int act, input int exp);
        check(act == exp, req, act, exp);
    endtask

    // Write both registers in one cycle; returns at the negedge of cycle 0.
    task automatic cfg(input logic [1:0] s, input logic [7:0] n);
        @(negedge clk);
        sel_wr = 1'b1; sel_din = s; rate_wr = 1'b1; rate_din = n;
        @(negedge clk);
        sel_wr = 1'b0; rate_wr = 1'b0;
    endtask

    // Sample n cycles starting with the current one.
    task automatic window(input int n);
        first_os = -1; first_bit = -1; first_frame = -1;
        cnt_os = 0; cnt_bit = 0; cnt_frame = 0;
        for (int k = 0; k < n; k++) begin
            #1;
            if (os_tick)    begin cnt_os++;    if (first_os < 0)    first_os = k;    end
            if (bit_tick)   begin cnt_bit++;   if (first_bit < 0)   first_bit = k;   end
            if (frame_tick) begin cnt_frame++; if (first_frame < 0) first_frame = k; end
            @(negedge clk);
        end
    endtask

    task automatic t_reset;
        int hits = 0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); #1;
            if (os_tick || bit_tick || frame_tick) hits++;
        end
        check_eq("R7 strobes low in reset", hits, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        window(8);
        check_eq("R7 first os after reset", first_os, 0);
        check_eq("R7 os every cycle after reset", cnt_os, 8);
    endtask

    task automatic t_select;
        cfg(2'd1, 8'd0); window(6);
        check_eq("R1 sel1 first os", first_os, 3);
        cfg(2'd2, 8'd0); window(18);
        check_eq("R1 sel2 first os", first_os, 15);
        cfg(2'd3, 8'd0); window(66);
        check_eq("R1 sel3 first os", first_os, 63);
        check_eq("R1 sel3 os count", cnt_os, 1);
    endtask

    task automatic t_rate;
        cfg(2'd1, 8'd2); window(30);
        check_eq("R2 Q4 N2 first os", first_os, 11);
        check_eq("R2 Q4 N2 os count", cnt_os, 2);
        cfg(2'd0, 8'd255); window(260);
        check_eq("R2 N255 first os", first_os, 255);
    endtask

    task automatic t_chain;
        cfg(2'd0, 8'd2); window(36);
        check_eq("R3 first bit", first_bit, 4 * 3 - 1);
        check_eq("R3 bit count", cnt_bit, 3);
        check_eq("R3 os count", cnt_os, 12);
        check_eq("R4 first frame", first_frame, 12 * 3 - 1);
        check_eq("R4 frame count", cnt_frame, 1);
    endtask

    task automatic t_restart;
        cfg(2'd1, 8'd2); window(5);
        check_eq("R5 no os before restart", cnt_os, 0);
        @(negedge clk);
        rate_wr = 1'b1; rate_din = 8'd2;
        @(negedge clk);
        rate_wr = 1'b0;
        window(14);
        check_eq("R5 rate write restarts", first_os, 11);
        @(negedge clk);
        sel_wr = 1'b1; sel_din = 2'd0;
        @(negedge clk);
        sel_wr = 1'b0;
        window(4);
        check_eq("R5 sel write restarts", first_os, 2);
        cfg(2'd0, 8'd0);
        @(negedge clk);
        rate_wr = 1'b1; rate_din = 8'd0;
        #1;
        check_eq("R5 silent in write cycle", int'(os_tick), 0);
        @(negedge clk);
        rate_wr = 1'b0;
        window(2);
        check_eq("R5 os resumes after write", first_os, 0);
    endtask

    task automatic t_ext;
        int seen [5];
        ext_mode = 1'b1; ext_clk = 1'b0;
        cfg(2'd3, 8'd255);
        repeat (4) @(negedge clk);
        ext_clk = 1'b1;
        for (int k = 0; k < 5; k++) begin
            #1; seen[k] = int'(os_tick);
            @(negedge clk);
        end
        check_eq("R6 no os in cycle 1", seen[1], 0);
        check_eq("R6 os two edges after rise", seen[2], 1);
        check_eq("R6 os one cycle wide", seen[3], 0);
        ext_clk = 1'b0;
        repeat (4) @(negedge clk);
        cfg(2'd3, 8'd255);
        cnt_os = 0; cnt_bit = 0; cnt_frame = 0;
        for (int c = 0; c < 96; c++) begin
            if (c % 8 == 0) ext_clk = 1'b1;
            if (c % 8 == 4) ext_clk = 1'b0;
            #1;
            if (os_tick) cnt_os++;
            if (bit_tick) cnt_bit++;
            if (frame_tick) cnt_frame++;
            @(negedge clk);
        end
        check_eq("R6 one os per external edge", cnt_os, 12);
        check_eq("R6 bit ticks from external base", cnt_bit, 3);
        check_eq("R6 frame tick from external base", cnt_frame, 1);
        ext_mode = 1'b0;
    endtask

    initial begin
        t_reset();
        t_select();
        t_rate();
        t_chain();
        t_restart();
        t_ext();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule